// File: doc/BRIEF.md
# Harness Continuity Scan Sequencer

This block runs the electrical scan of a two-connector, sixteen-circuit harness tester. It owns the pin-addressing lines of an external switching matrix. Each point of the scan enables one source pin on the A connector and one sense pin on the B connector, then reads a single sampled continuity line. From these reads it builds a 16x16 bit map of the harness. Bit (a,b) is set when pin a on side A connects to pin b on side B.

An unstable contact can make a single sweep look clean or faulty at random. To guard against that, the block sweeps the whole map twice and keeps each pass in its own buffer. It then compares the two passes row by row. If the passes agree, it publishes the map. If any cell differs, it reports an unstable result so the operator re-seats the harness, and it publishes no map. Host logic pulses a start input, waits for done and reads the outcome flags. The verdict logic downstream classifies opens, shorts and swaps from the published map.

The switching matrix needs time to settle after each address change. For this reason every point waits a number of clocks set at start before it samples.

Top module: `harness_scan_seq`

## Requirements
- R1: After synchronous reset, busy, done, matrix_valid and unstable are 0. drive_en and sense_en are 0, both select buses are 0 and matrix_out is all zeros.
- R2: A start pulse seen while idle makes busy, drive_en and sense_en read 1 in the next cycle, with drive_sel = 0, sense_sel = 0 and matrix_out cleared to zero.
- R3: Each pass visits all 256 points in row-major order. sense_sel (B pin) is the inner index and drive_sel (A pin) the outer one, and both count 0 to 15. The block runs exactly two passes per scan, 512 points in all.
- R4: settle_cycles is captured at start. After each select change, cont_in is sampled on the (settle_cycles+1)-th rising edge following that change. Each extra settle clock therefore lengthens a scan by 512 cycles.
- R5: When both passes agree, bit a*16+b of matrix_out holds the continuity read between A pin a and B pin b (1 = connected).
- R6: A scan whose passes agree ends with done and matrix_valid high for the same cycle, busy low in that cycle, and the map held on matrix_out.
- R7: A difference in any single cell between the two passes ends the scan with done and unstable high, matrix_valid low and matrix_out all zeros.
- R8: start is ignored while busy. Extra start pulses during a scan neither restart it, change its length nor add a done pulse.
- R9: done lasts one clock and comes with exactly one of matrix_valid or unstable. Neither flag is high without done. Whenever busy is low, both enables and both selects are 0.
- R10: Asserting reset during a scan aborts it. The block returns to the R1 state and produces no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (ignored while busy) |
| settle_cycles | input | 8 | Settle clocks per point, captured at start |
| cont_in | input | 1 | Sampled continuity between the selected pins |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| matrix_valid | output | 1 | With done: passes agreed, map valid |
| unstable | output | 1 | With done: passes disagreed, re-seat harness |
| drive_en | output | 1 | A-side source enable |
| drive_sel | output | 4 | A-side pin address |
| sense_en | output | 1 | B-side sense enable |
| sense_sel | output | 4 | B-side pin address |
| matrix_out | output | 256 | Connectivity map, bit a*16+b |

## Verification
The bench sweeps a behavioural harness through several patterns:
- a straight-through map;
- a two-wire swap;
- a mixed map with an open row, a bridged row and an all-connected row.

A correct map for each shows that rows and columns are neither transposed nor shifted. The model inverts its continuity answer whenever the selects changed fewer than settle_cycles clocks earlier, so any early sample corrupts the map. Comparing scan lengths at two settle values pins down the per-point wait. The model also flips one cell during the second pass only, at a corner, in the middle and at the last cell. This separates a true bitwise consistency check from one that looks at part of the map.

// File: rtl/hss_pkg.sv
package hss_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SCAN = 2'd1,
    S_CMP  = 2'd2
  } scan_state_e;
endpackage

// File: rtl/hss_addr_gen.sv
// Row-major point walker: B index inner, A index outer, pass bit on wrap.
module hss_addr_gen #(
  parameter int N_A = 16,
  parameter int N_B = 16,
  localparam int AW = $clog2(N_A),
  localparam int BW = $clog2(N_B)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [AW-1:0] a_idx,
  output logic [BW-1:0] b_idx,
  output logic          pass,
  output logic          last_col,
  output logic          last_point
);
  assign last_col   = (b_idx == BW'(N_B - 1));
  assign last_point = last_col && (a_idx == AW'(N_A - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      a_idx <= '0;
      b_idx <= '0;
      pass  <= 1'b0;
    end else if (step) begin
      if (last_col) begin
        b_idx <= '0;
        if (a_idx == AW'(N_A - 1)) begin
          a_idx <= '0;
          pass  <= ~pass;
        end else begin
          a_idx <= a_idx + 1'b1;
        end
      end else begin
        b_idx <= b_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hss_settle_timer.sv
// Down-counter; expired while zero, reloaded on every point change.
module hss_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] count;

  assign expired = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (!expired) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/hss_row_ram.sv
// Simple dual-port row store, registered read, no reset (RAM inferable).
module hss_row_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/harness_scan_seq.sv
module harness_scan_seq
  import hss_pkg::*;
#(
  parameter int N_A = 16,
  parameter int N_B = 16,
  parameter int SETTLE_W = 8,
  localparam int AW = $clog2(N_A),
  localparam int BW = $clog2(N_B),
  localparam int CELLS = N_A * N_B
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                cont_in,
  output logic                busy,
  output logic                done,
  output logic                matrix_valid,
  output logic                unstable,
  output logic                drive_en,
  output logic [AW-1:0]       drive_sel,
  output logic                sense_en,
  output logic [BW-1:0]       sense_sel,
  output logic [CELLS-1:0]    matrix_out
);
  localparam int NPASS = 2;

  scan_state_e         state;
  logic [SETTLE_W-1:0] settle_q;
  logic [N_B-1:0]      row_acc;
  logic [N_B-1:0]      row_next;
  logic [AW-1:0]       cmp_addr;
  logic                cmp_issue;
  logic                rd_valid;
  logic [AW-1:0]       rd_row;
  logic                mismatch;
  logic                mismatch_n;
  logic                start_acc;
  logic                sample;
  logic                expired;
  logic                pass;
  logic                last_col;
  logic                last_point;
  logic [N_B-1:0]      rd_data [NPASS];

  assign start_acc = (state == S_IDLE) && start;
  assign sample    = (state == S_SCAN) && expired;

  hss_addr_gen #(.N_A(N_A), .N_B(N_B)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .clear      (start_acc),
    .step       (sample),
    .a_idx      (drive_sel),
    .b_idx      (sense_sel),
    .pass       (pass),
    .last_col   (last_col),
    .last_point (last_point)
  );

  hss_settle_timer #(.W(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst      (rst),
    .load     (start_acc || sample),
    .load_val (start_acc ? settle_cycles : settle_q),
    .expired  (expired)
  );

  // Row being assembled: previous points of this row plus the current read.
  always_comb begin
    row_next = row_acc;
    row_next[sense_sel] = cont_in;
  end

  // One row store per pass; a completed row is written in a single cycle.
  for (genvar g = 0; g < NPASS; g++) begin : g_pass_buf
    hss_row_ram #(.DEPTH(N_A), .WIDTH(N_B)) u_buf (
      .clk   (clk),
      .we    (sample && last_col && (pass == 1'(g))),
      .waddr (drive_sel),
      .wdata (row_next),
      .raddr (cmp_addr),
      .rdata (rd_data[g])
    );
  end

  assign mismatch_n = mismatch | (rd_data[0] != rd_data[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      busy         <= 1'b0;
      done         <= 1'b0;
      matrix_valid <= 1'b0;
      unstable     <= 1'b0;
      drive_en     <= 1'b0;
      sense_en     <= 1'b0;
      settle_q     <= '0;
      row_acc      <= '0;
      cmp_addr     <= '0;
      cmp_issue    <= 1'b0;
      rd_valid     <= 1'b0;
      rd_row       <= '0;
      mismatch     <= 1'b0;
      matrix_out   <= '0;
    end else begin
      done         <= 1'b0;
      matrix_valid <= 1'b0;
      unstable     <= 1'b0;
      rd_valid     <= cmp_issue;
      rd_row       <= cmp_addr;
      case (state)
        S_IDLE: begin
          if (start) begin
            state      <= S_SCAN;
            busy       <= 1'b1;
            drive_en   <= 1'b1;
            sense_en   <= 1'b1;
            settle_q   <= settle_cycles;
            row_acc    <= '0;
            mismatch   <= 1'b0;
            matrix_out <= '0;
          end
        end
        S_SCAN: begin
          if (sample) begin
            row_acc <= last_col ? '0 : row_next;
            if (last_point && pass) begin
              state     <= S_CMP;
              drive_en  <= 1'b0;
              sense_en  <= 1'b0;
              cmp_addr  <= '0;
              cmp_issue <= 1'b1;
            end
          end
        end
        S_CMP: begin
          if (cmp_issue) begin
            if (cmp_addr == AW'(N_A - 1)) cmp_issue <= 1'b0;
            else cmp_addr <= cmp_addr + 1'b1;
          end
          if (rd_valid) begin
            matrix_out[int'(rd_row) * N_B +: N_B] <= rd_data[0];
            mismatch <= mismatch_n;
            if (rd_row == AW'(N_A - 1)) begin
              state        <= S_IDLE;
              busy         <= 1'b0;
              done         <= 1'b1;
              matrix_valid <= !mismatch_n;
              unstable     <= mismatch_n;
              if (mismatch_n) matrix_out <= '0;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hss_chk.sv
module hss_chk #(
  parameter int N_A = 16,
  parameter int N_B = 16,
  localparam int AW = $clog2(N_A),
  localparam int BW = $clog2(N_B)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          matrix_valid,
  input logic          unstable,
  input logic          drive_en,
  input logic [AW-1:0] drive_sel,
  input logic          sense_en,
  input logic [BW-1:0] sense_sel
);
  // R9
  done_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (matrix_valid ^ unstable));

  // R9
  flag_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    (matrix_valid || unstable) |-> done);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!drive_en && !sense_en && drive_sel == '0 && sense_sel == '0));

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R2
  scan_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(start) && drive_en && sense_en &&
                     drive_sel == '0 && sense_sel == '0));

  // R3
  sense_step_chk: assert property (@(posedge clk) disable iff (rst)
    (drive_en && $past(drive_en) && sense_sel != $past(sense_sel)) |->
      (sense_sel == $past(sense_sel) + 1'b1 ||
       (sense_sel == '0 && $past(sense_sel) == BW'(N_B - 1))));

  // R3
  drive_step_chk: assert property (@(posedge clk) disable iff (rst)
    (drive_en && $past(drive_en) && drive_sel != $past(drive_sel)) |->
      ($past(sense_sel) == BW'(N_B - 1) && sense_sel == '0));
endmodule

bind harness_scan_seq hss_chk #(.N_A(N_A), .N_B(N_B)) u_hss_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .matrix_valid (matrix_valid),
  .unstable     (unstable),
  .drive_en     (drive_en),
  .drive_sel    (drive_sel),
  .sense_en     (sense_en),
  .sense_sel    (sense_sel)
);

// File: tb/tb_harness_scan_seq.sv
module tb_harness_scan_seq;
  localparam int NA = 16;
  localparam int NB = 16;
  localparam int SW = 8;
  localparam int CELLS = NA * NB;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [SW-1:0]    settle_cycles = '0;
  logic             cont_in = 1'b0;
  logic             busy, done, matrix_valid, unstable;
  logic             drive_en, sense_en;
  logic [3:0]       drive_sel, sense_sel;
  logic [CELLS-1:0] matrix_out;

  harness_scan_seq dut (
    .clk(clk), .rst(rst), .start(start), .settle_cycles(settle_cycles),
    .cont_in(cont_in), .busy(busy), .done(done), .matrix_valid(matrix_valid),
    .unstable(unstable), .drive_en(drive_en), .drive_sel(drive_sel),
    .sense_en(sense_en), .sense_sel(sense_sel), .matrix_out(matrix_out)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Behavioural harness and switching-matrix model.
  logic [NB-1:0] conn [NA];
  bit glitch_en = 0;
  int glitch_a = 0, glitch_b = 0;
  int settle_tb = 0;
  int age = 0;
  bit pass2 = 0;
  bit prev_en = 0;
  int prev_d = 0, prev_s = 0;
  int pts = 0, order_err = 0, done_cnt = 0;

  always @(negedge clk) begin
    bit v;
    if (drive_en) begin
      if (!prev_en || int'(drive_sel) != prev_d || int'(sense_sel) != prev_s) begin
        if (prev_en && prev_d == NA - 1 && prev_s == NB - 1) pass2 = 1;
        if (int'(drive_sel) != (pts % CELLS) / NB || int'(sense_sel) != pts % NB)
          order_err++;
        pts++;
        age = 0;
      end else begin
        age++;
      end
    end else begin
      pass2 = 0;
      age = 0;
    end
    prev_en = drive_en;
    prev_d  = int'(drive_sel);
    prev_s  = int'(sense_sel);
    v = conn[drive_sel][sense_sel];
    if (glitch_en && pass2 && int'(drive_sel) == glitch_a && int'(sense_sel) == glitch_b)
      v = !v;
    if (age < settle_tb) v = !v;   // not yet settled: wrong answer
    cont_in = drive_en && sense_en && v;
    if (done) done_cnt++;
  end

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [CELLS-1:0] flat_map();
    logic [CELLS-1:0] r;
    for (int a = 0; a < NA; a++)
      for (int b = 0; b < NB; b++)
        r[a*NB + b] = conn[a][b];
    return r;
  endfunction

  task automatic set_identity();
    for (int a = 0; a < NA; a++) conn[a] = NB'(1) << a;
  endtask

  task automatic idle_check(input string tag);
    chk(!busy && !done && !matrix_valid && !unstable && !drive_en && !sense_en &&
        drive_sel == 0 && sense_sel == 0,
        $sformatf("%s idle state actual busy=%0b done=%0b en=%0b%0b sel=%0d/%0d expected all 0",
                  tag, busy, done, drive_en, sense_en, drive_sel, sense_sel));
  endtask

  // One scan; poke1/poke2 (>0) pulse start at that cycle count mid-scan.
  task automatic run_scan(input int s, input int poke1, input int poke2,
                          output int cyc, output bit v, output bit u,
                          output logic [CELLS-1:0] m);
    int n;
    settle_cycles = SW'(s);
    settle_tb = s;
    @(negedge clk);
    pts = 0;
    order_err = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: accepted start seen one cycle later
    chk(busy && drive_en && sense_en && drive_sel == 0 && sense_sel == 0 && matrix_out == '0,
        $sformatf("R2 scan entry actual busy=%0b en=%0b%0b sel=%0d/%0d expected 1,11,0/0 map 0",
                  busy, drive_en, sense_en, drive_sel, sense_sel));
    n = 1;
    while (!done && n < 40000) begin
      @(negedge clk);
      n++;
      start = (n == poke1 || n == poke2);
    end
    start = 1'b0;
    cyc = n;
    v = matrix_valid;
    u = unstable;
    m = matrix_out;
    chk(done && !busy, $sformatf("R6 done with busy low actual done=%0b busy=%0b expected 1/0",
                                 done, busy));
    @(negedge clk);
    chk(!done && !matrix_valid && !unstable,
        $sformatf("R9 done one cycle actual done=%0b v=%0b u=%0b expected 0", done,
                  matrix_valid, unstable));
    idle_check("R9");
  endtask

  task automatic t_reset();
    idle_check("R1");
    chk(matrix_out == '0, $sformatf("R1 map cleared actual=%h expected 0", matrix_out));
  endtask

  task automatic t_identity();
    int c; bit v, u; logic [CELLS-1:0] m;
    set_identity();
    run_scan(2, 0, 0, c, v, u, m);
    chk(pts == 2 * CELLS && order_err == 0,
        $sformatf("R3 row-major two passes actual pts=%0d order_err=%0d expected %0d/0",
                  pts, order_err, 2 * CELLS));
    chk(v && !u, $sformatf("R6 straight map valid actual v=%0b u=%0b expected 1/0", v, u));
    chk(m == flat_map(), $sformatf("R5 straight map actual=%h expected=%h", m, flat_map()));
  endtask

  task automatic t_swap();
    int c; bit v, u; logic [CELLS-1:0] m;
    set_identity();
    conn[3] = NB'(1) << 9;
    conn[9] = NB'(1) << 3;
    run_scan(0, 0, 0, c, v, u, m);
    chk(v && m == flat_map(), $sformatf("R5 swapped pair actual=%h expected=%h", m, flat_map()));
    chk(pts == 2 * CELLS && order_err == 0,
        $sformatf("R3 order zero settle actual pts=%0d err=%0d expected %0d/0", pts, order_err,
                  2 * CELLS));
  endtask

  task automatic t_faults();
    int c; bit v, u; logic [CELLS-1:0] m;
    set_identity();
    conn[0]  = '1;
    conn[5]  = '0;
    conn[7]  = 16'h0180;
    conn[15] = 16'h8001;
    run_scan(3, 0, 0, c, v, u, m);
    chk(v && !u, $sformatf("R6 fault map valid actual v=%0b u=%0b expected 1/0", v, u));
    chk(m == flat_map(), $sformatf("R5 open/short map actual=%h expected=%h", m, flat_map()));
  endtask

  task automatic t_settle();
    int c1, c5; bit v, u; logic [CELLS-1:0] m;
    set_identity();
    conn[10] = 16'h5a5a;
    run_scan(1, 0, 0, c1, v, u, m);
    chk(v && m == flat_map(), $sformatf("R4 settle 1 map actual=%h expected=%h", m, flat_map()));
    run_scan(5, 0, 0, c5, v, u, m);
    chk(v && m == flat_map(), $sformatf("R4 settle 5 map actual=%h expected=%h", m, flat_map()));
    chk(c5 - c1 == 2 * CELLS * 4,
        $sformatf("R4 settle length delta actual=%0d expected=%0d", c5 - c1, 2 * CELLS * 4));
  endtask

  task automatic glitch_one(input int a, input int b);
    int c; bit v, u; logic [CELLS-1:0] m;
    glitch_a = a;
    glitch_b = b;
    glitch_en = 1;
    run_scan(1, 0, 0, c, v, u, m);
    glitch_en = 0;
    chk(u && !v, $sformatf("R7 cell %0d,%0d unstable actual v=%0b u=%0b expected 0/1",
                           a, b, v, u));
    chk(m == '0, $sformatf("R7 cell %0d,%0d map withheld actual=%h expected 0", a, b, m));
  endtask

  task automatic t_glitch();
    int c; bit v, u; logic [CELLS-1:0] m;
    set_identity();
    glitch_one(0, 0);
    glitch_one(12, 4);
    glitch_one(15, 15);
    run_scan(1, 0, 0, c, v, u, m);
    chk(v && !u && m == flat_map(),
        $sformatf("R6 clean rescan after unstable actual v=%0b u=%0b", v, u));
  endtask

  task automatic t_busy_start();
    int cref, c, d0; bit v, u; logic [CELLS-1:0] m;
    set_identity();
    conn[2] = 16'h0f0f;
    run_scan(1, 0, 0, cref, v, u, m);
    d0 = done_cnt;
    run_scan(1, 40, cref - 4, c, v, u, m);
    repeat (4) @(negedge clk);
    chk(c == cref, $sformatf("R8 length with extra starts actual=%0d expected=%0d", c, cref));
    chk(done_cnt - d0 == 1, $sformatf("R8 done count actual=%0d expected=1", done_cnt - d0));
    chk(v && m == flat_map(), $sformatf("R8 map unchanged actual=%h expected=%h", m, flat_map()));
    idle_check("R8");
  endtask

  task automatic t_abort();
    int c, d0; bit v, u; logic [CELLS-1:0] m;
    set_identity();
    settle_cycles = SW'(2);
    settle_tb = 2;
    @(negedge clk);
    pts = 0;
    order_err = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (300) @(negedge clk);
    d0 = done_cnt;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_check("R10");
    chk(matrix_out == '0, $sformatf("R10 map cleared actual=%h expected 0", matrix_out));
    repeat (1600) @(negedge clk);
    chk(done_cnt == d0, $sformatf("R10 no done after abort actual=%0d expected=%0d",
                                  done_cnt, d0));
    run_scan(2, 0, 0, c, v, u, m);
    chk(v && m == flat_map(), $sformatf("R10 scan after abort actual=%h expected=%h",
                                        m, flat_map()));
  endtask

  initial begin
    for (int a = 0; a < NA; a++) conn[a] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_identity();
    t_swap();
    t_faults();
    t_settle();
    t_glitch();
    t_busy_start();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule